// File: doc/BRIEF.md
# Local Contrast Normalization Pixel Stage

This block is the per-pixel arithmetic of a local contrast normalizer in a streaming video path. Each incoming pixel arrives together with a blurred background value that has already been aligned to it. The stage subtracts the background to get a signed high-pass value. It keeps the sign and the magnitude, and sends a power-law compressed copy of the magnitude (exponent 0.75, read from a computed lookup table) to an external smoothing filter.

The smoothing filters are two-dimensional Gaussians, sigma 4.2, with 25 taps per dimension, applied one dimension at a time. They sit outside this block. When the smoothed contrast comes back, the stage pairs it with the sign and magnitude it has held in an alignment FIFO. It clips the contrast to a safe divisor range and divides the magnitude by it in a bit-serial pipelined divider. It then scales the quotient by 150, restores the sign, re-centres the result on mid-grey and saturates it to 8 bits.

Input ready is removed while the alignment FIFO is full, so the external filter latency is limited only by the FIFO depth.

Top module: `lcn_pixel_stage`

## Requirements
- R1: A pixel is accepted on a clock edge where in_valid_i and in_ready_o are both high. Its magnitude is |pix - bg|, and its sign is negative exactly when pix < bg.
- R2: pw_valid_o is high in the cycle after each accepted pixel and low otherwise. pw_data_o = round(255 * (m/255)^0.75), where m is that pixel's magnitude.
- R3: in_ready_o is high after reset. It falls once FIFO_DEPTH (16 by default) accepted pixels are still waiting for their contrast. A pixel presented while in_ready_o is low is not taken and produces no power-law output.
- R4: Each ret_valid_i pulse pairs with the oldest accepted pixel that has not yet been paired, in acceptance order.
- R5: A returned contrast below 50 is used as 50, one above 255 is used as 255, and any other value is used unchanged.
- R6: The scaled magnitude is s = (floor(m*256/c) * 150 + 128) >> 8, where c is the clipped contrast.
- R7: The output pixel is 128 + s for a non-negative sign and 128 - s for a negative sign, saturated to the range 0..255.
- R8: out_valid_o pulses exactly once for each returned contrast, in return order, QW+2 cycles after the ret_valid_i cycle. QW is 11 by default, which gives 13 cycles.
- R9: While reset is held, in_ready_o is 1 and pw_valid_o and out_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Stage can accept a pixel |
| in_pix_i | input | PIX_W | Raw pixel |
| in_bg_i | input | PIX_W | Aligned blurred background |
| pw_valid_o | output | 1 | Power-law value valid |
| pw_data_o | output | PIX_W | Compressed contrast magnitude to the smoothing filter |
| ret_valid_i | input | 1 | Smoothed contrast valid |
| ret_con_i | input | CON_W | Smoothed local contrast |
| out_valid_o | output | 1 | Normalized pixel valid |
| out_pix_o | output | PIX_W | Normalized pixel |

## Verification
The assertions check the following on every cycle:
- the power-law output follows each accepted pixel by one cycle, and only then;
- ready falls only after an accept;
- the FIFO never overflows or underflows;
- every divisor entering the divider is inside the clip range;
- every divider stage keeps its partial remainder below the divisor.

Only the bench's scenarios show the numeric behaviour: the lookup values across all magnitudes, the pairing order of returned contrasts, the clip and saturation corners of the output, the exact output latency, and the exact fill level at which ready drops.

// File: rtl/lcn_pkg.sv
package lcn_pkg;

  // round(full * (m/full)^0.75) = round((m^3 * full)^(1/4)), found exactly in integers
  function automatic int unsigned pow34_round(int unsigned m, int unsigned full);
    longint unsigned y;
    longint unsigned t;
    longint unsigned k;
    y = 64'(m) * 64'(m) * 64'(m) * 64'(full) * 64'd16;
    k = 0;
    for (int b = 11; b >= 0; b--) begin
      t = k | (64'd1 << b);
      if (t * t * t * t <= y) k = t;
    end
    // k = floor(2*r), so (k+1)>>1 = round(r)
    return int'((k + 64'd1) >> 1);
  endfunction

endpackage

// File: rtl/lcn_pow_lut.sv
module lcn_pow_lut #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] mag_i,
  output logic [PIX_W-1:0] pw_o
);
  localparam int N = 2 ** PIX_W;

  logic [PIX_W-1:0] tbl [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    localparam int unsigned V = lcn_pkg::pow34_round(g, N - 1);
    assign tbl[g] = PIX_W'(V);
  end

  assign pw_o = tbl[mag_i];
endmodule

// File: rtl/lcn_align_fifo.sv
module lcn_align_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  assign data_o  = mem[rd_ptr];
  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/lcn_div_pipe.sv
module lcn_div_pipe #(
  parameter int NW   = 16,
  parameter int DW   = 8,
  parameter int QW   = 11,
  parameter int CMIN = 50,
  parameter int CMAX = 255
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sign_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic          valid_o,
  output logic          sign_o,
  output logic [QW-1:0] quo_o
);
  // stage k holds the state after k quotient bits
  logic          vld [QW+1];
  logic          sgn [QW+1];
  logic [DW:0]   rem [QW+1];
  logic [DW-1:0] den [QW+1];
  logic [QW-1:0] quo [QW+1];
  logic [QW-1:0] lo  [QW];

  logic [DW:0] trial [QW];
  logic        ge    [QW];
  logic [DW:0] nrem  [QW];

  always_comb begin
    for (int k = 0; k < QW; k++) begin
      trial[k] = {rem[k][DW-1:0], lo[k][QW-1]};
      ge[k]    = trial[k] >= {1'b0, den[k]};
      nrem[k]  = ge[k] ? trial[k] - {1'b0, den[k]} : trial[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= QW; k++) vld[k] <= 1'b0;
    end else begin
      vld[0] <= valid_i;
      for (int k = 0; k < QW; k++) vld[k+1] <= vld[k];
    end
  end

  always_ff @(posedge clk_i) begin
    // quotient fits QW bits, so the top of the dividend is already below den
    rem[0] <= (DW+1)'(num_i >> QW);
    lo[0]  <= num_i[QW-1:0];
    quo[0] <= '0;
    den[0] <= den_i;
    sgn[0] <= sign_i;
    for (int k = 0; k < QW; k++) begin
      rem[k+1] <= nrem[k];
      quo[k+1] <= {quo[k][QW-2:0], ge[k]};
      den[k+1] <= den[k];
      sgn[k+1] <= sgn[k];
    end
    for (int k = 0; k < QW - 1; k++) lo[k+1] <= lo[k] << 1;
  end

  assign valid_o = vld[QW];
  assign sign_o  = sgn[QW];
  assign quo_o   = quo[QW];

  for (genvar k = 0; k <= QW; k++) begin : g_chk
    p_rem_below_den_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld[k] |-> rem[k] < {1'b0, den[k]});
  end

  p_den_in_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (den_i >= DW'(CMIN)) && (den_i <= DW'(CMAX)));
endmodule

// File: rtl/lcn_pixel_stage.sv
module lcn_pixel_stage #(
  parameter int PIX_W      = 8,
  parameter int CON_W      = 10,
  parameter int FIFO_DEPTH = 16,
  parameter int FRAC_W     = 8,
  parameter int GAIN       = 150,
  parameter int MID        = 128,
  parameter int CMIN       = 50,
  parameter int CMAX       = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] in_pix_i,
  input  logic [PIX_W-1:0] in_bg_i,
  output logic             pw_valid_o,
  output logic [PIX_W-1:0] pw_data_o,
  input  logic             ret_valid_i,
  input  logic [CON_W-1:0] ret_con_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] out_pix_o
);
  localparam int PMAX = 2 ** PIX_W - 1;
  localparam int DW   = $clog2(CMAX + 1);
  localparam int NW   = PIX_W + FRAC_W;
  localparam int QW   = $clog2(((PMAX << FRAC_W) / CMIN) + 1);
  localparam int PW   = QW + $clog2(GAIN + 1) + 1;
  localparam int EW   = PIX_W + 1;

  logic             accept;
  logic             neg;
  logic [PIX_W-1:0] mag;
  logic [PIX_W-1:0] pw_next;
  logic             fifo_full, fifo_empty;
  logic [EW-1:0]    fifo_rd;
  logic [DW-1:0]    den;
  logic             div_valid, div_sign;
  logic [QW-1:0]    div_quo;
  logic [PW-1:0]    prod, scaled;
  logic [PIX_W-1:0] res;

  // front end: background removal and sign/magnitude split
  assign in_ready_o = !fifo_full;
  assign accept     = in_valid_i && in_ready_o;
  assign neg        = in_pix_i < in_bg_i;
  assign mag        = neg ? in_bg_i - in_pix_i : in_pix_i - in_bg_i;

  lcn_pow_lut #(.PIX_W(PIX_W)) u_lut (
    .mag_i (mag),
    .pw_o  (pw_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_valid_o <= 1'b0;
      pw_data_o  <= '0;
    end else begin
      pw_valid_o <= accept;
      if (accept) pw_data_o <= pw_next;
    end
  end

  lcn_align_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept),
    .data_i  ({neg, mag}),
    .pop_i   (ret_valid_i),
    .data_o  (fifo_rd),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  // returned contrast is clipped into the divisor range
  always_comb begin
    if (ret_con_i < CON_W'(CMIN))      den = DW'(CMIN);
    else if (ret_con_i > CON_W'(CMAX)) den = DW'(CMAX);
    else                               den = DW'(ret_con_i);
  end

  lcn_div_pipe #(.NW(NW), .DW(DW), .QW(QW), .CMIN(CMIN), .CMAX(CMAX)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ret_valid_i),
    .sign_i  (fifo_rd[EW-1]),
    .num_i   ({fifo_rd[PIX_W-1:0], {FRAC_W{1'b0}}}),
    .den_i   (den),
    .valid_o (div_valid),
    .sign_o  (div_sign),
    .quo_o   (div_quo)
  );

  // gain, round to nearest, re-centre, saturate
  always_comb begin
    prod   = PW'(div_quo) * PW'(GAIN) + PW'(2 ** (FRAC_W - 1));
    scaled = prod >> FRAC_W;
    if (div_sign)
      res = (scaled > PW'(MID)) ? '0 : PIX_W'(PW'(MID) - scaled);
    else
      res = (scaled > PW'(PMAX - MID)) ? PIX_W'(PMAX) : PIX_W'(PW'(MID) + scaled);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
    end else begin
      out_valid_o <= div_valid;
      if (div_valid) out_pix_o <= res;
    end
  end

  p_pw_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> pw_valid_o);
  p_pw_only_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !pw_valid_o);
  p_ready_falls_on_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_ready_o) |-> $past(accept));
  p_ret_has_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |-> !fifo_empty);
  p_out_after_div_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_valid |=> out_valid_o);
endmodule

// File: tb/sim_lcn_pixel_stage.sv
module sim_lcn_pixel_stage;
  localparam int DEPTH = 16;
  localparam int LAT   = 13;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] in_pix_i = '0;
  logic [7:0] in_bg_i = '0;
  logic       pw_valid_o;
  logic [7:0] pw_data_o;
  logic       ret_valid_i = 1'b0;
  logic [9:0] ret_con_i = '0;
  logic       out_valid_o;
  logic [7:0] out_pix_o;

  always #10 clk = ~clk;

  lcn_pixel_stage #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_pix_i    (in_pix_i),
    .in_bg_i     (in_bg_i),
    .pw_valid_o  (pw_valid_o),
    .pw_data_o   (pw_data_o),
    .ret_valid_i (ret_valid_i),
    .ret_con_i   (ret_con_i),
    .out_valid_o (out_valid_o),
    .out_pix_o   (out_pix_o)
  );

  int      total = 0;
  int      bad = 0;
  bit      done = 0;
  longint  cyc = 0;
  int      exp_pw[$];
  int      pend_mag[$];
  bit      pend_neg[$];
  int      exp_out[$];
  longint  exp_cyc[$];
  int      pw_seen = 0;
  int      returned = 0;
  bit      ret_en = 0;
  int      ret_gap = 0;
  int      cons[12] = '{0, 10, 49, 50, 51, 77, 128, 200, 255, 256, 300, 1023};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  function automatic int ref_pw(int m);
    real r;
    r = 255.0 * $pow(real'(m) / 255.0, 0.75);
    return $rtoi(r + 0.5);
  endfunction

  function automatic int ref_out(bit n, int m, int c);
    int cc, q, s, v;
    cc = (c < 50) ? 50 : ((c > 255) ? 255 : c);
    q  = (m * 256) / cc;
    s  = (q * 150 + 128) >>> 8;
    v  = n ? 128 - s : 128 + s;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  function automatic void record(int p, int b);
    bit n;
    int m;
    n = p < b;
    m = n ? b - p : p - b;
    exp_pw.push_back(ref_pw(m));
    pend_neg.push_back(n);
    pend_mag.push_back(m);
  endfunction

  // output monitor and external smoothing-filter model
  always @(negedge clk) begin
    if (rst_n) begin
      if (pw_valid_o) begin
        if (exp_pw.size() == 0) chk(0, "R2 unexpected pw", pw_data_o, -1);
        else begin
          int e;
          e = exp_pw.pop_front();
          chk(pw_data_o == 8'(e), "R2 power-law value", pw_data_o, e);
        end
        pw_seen++;
      end
      if (out_valid_o) begin
        if (exp_out.size() == 0) chk(0, "R8 unexpected out", out_pix_o, -1);
        else begin
          int e;
          longint lc;
          e  = exp_out.pop_front();
          lc = exp_cyc.pop_front();
          chk(out_pix_o == 8'(e), "R6 R7 normalized pixel", out_pix_o, e);
          chk(cyc - lc == LAT, "R8 latency", cyc - lc, LAT);
        end
      end
      if (ret_en && returned < pw_seen && (cyc % (ret_gap + 1)) == 0) begin
        int c, m;
        bit n;
        c = cons[returned % 12];
        n = pend_neg.pop_front();
        m = pend_mag.pop_front();
        ret_valid_i = 1'b1;
        ret_con_i   = 10'(c);
        exp_out.push_back(ref_out(n, m, c)); // R4 R5: oldest pixel, clipped contrast
        exp_cyc.push_back(cyc);
        returned++;
      end else begin
        ret_valid_i = 1'b0;
      end
    end
  end

  task automatic send(int p, int b);
    in_valid_i = 1'b1;
    in_pix_i   = 8'(p);
    in_bg_i    = 8'(b);
    forever begin
      if (in_ready_o) begin
        record(p, b); // R1
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (pend_mag.size() != 0 || exp_out.size() != 0 || exp_pw.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int acc, snap;
    repeat (3) @(negedge clk);
    chk(in_ready_o == 1'b1, "R9 ready in reset", in_ready_o, 1);
    chk(pw_valid_o == 1'b0, "R9 pw_valid in reset", pw_valid_o, 0);
    chk(out_valid_o == 1'b0, "R9 out_valid in reset", out_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: all positive magnitudes, then all negative ones
    ret_en = 1;
    ret_gap = 0;
    for (int i = 0; i < 256; i++) send(i, 0);
    for (int i = 0; i < 256; i++) send(0, i);
    in_valid_i = 1'b0;
    drain();

    // mixed pixels with slower returns
    ret_gap = 2;
    for (int i = 0; i < 300; i++) send((i * 37) % 256, (i * 101 + 13) % 256);
    in_valid_i = 1'b0;
    drain();

    // R3: fill the alignment FIFO with no returns
    ret_en = 0;
    acc = 0;
    for (int i = 0; i < DEPTH + 4; i++) begin
      in_valid_i = 1'b1;
      in_pix_i   = 8'(200 - i);
      in_bg_i    = 8'(i * 3);
      if (in_ready_o) begin
        record(200 - i, i * 3);
        acc++;
      end
      @(negedge clk);
    end
    chk(acc == DEPTH, "R3 accepted before full", acc, DEPTH);
    chk(in_ready_o == 1'b0, "R3 ready low when full", in_ready_o, 0);
    snap = pw_seen;
    repeat (5) @(negedge clk);
    chk(pw_seen == snap, "R3 no pw while not ready", pw_seen, snap);
    chk(in_ready_o == 1'b0, "R3 ready stays low", in_ready_o, 0);
    in_valid_i = 1'b0;
    ret_en = 1;
    ret_gap = 0;
    drain();
    chk(in_ready_o == 1'b1, "R3 ready back after drain", in_ready_o, 1);

    // R4 R8: back-to-back run while returns lag
    ret_gap = 1;
    for (int i = 0; i < 64; i++) send(255 - (i * 7) % 256, (i * 11) % 256);
    in_valid_i = 1'b0;
    drain();
    repeat (LAT + 4) @(negedge clk);
    chk(exp_out.size() == 0, "R8 one output per return", exp_out.size(), 0);
    chk(returned == pw_seen, "R4 every pixel paired", returned, pw_seen);
    finish_run();
  end
endmodule